// File: doc/BRIEF.md
# Bus-Matching FIFO Read Port with Byte-Order Swap

This block sits on the output side of a 36-bit FIFO and lets a consumer read each 36-bit long word over a 36-bit, 18-bit or 9-bit bus. The long word is split into one, two or four pieces, one piece per accepted read. The FIFO is popped only when the last piece of a long word has been delivered. Before slicing, the long word passes through one of four byte-order swap modes. The mode is taken when the first piece is read and held for the rest of that long word.

The bus-size and piece-order controls go through a two-register pipeline. The first rising edge captures them and the next rising edge makes them active. One size code does not read the FIFO at all. It selects a mailbox register for a full-width transfer and raises a mailbox select output. Packing on the write side is handled elsewhere.

Top module: `bm_rd_port`

## Requirements
- R1: With size code 00 (long word), each accepted read puts the whole swapped 36-bit word on `dout` and pulses `fifo_pop` for one cycle. Both are registered, so they appear after the read edge.
- R2: With size code 01 (word), a long word takes two accepted reads. Each read puts an 18-bit half on `dout[17:0]` with `dout[35:18]` at zero. `fifo_pop` pulses only with the second read.
- R3: With size code 10 (byte), a long word takes four accepted reads. Each read puts one 9-bit lane on `dout[8:0]` with the upper bits at zero. `fifo_pop` pulses only with the fourth read.
- R4: `order_sel`=1 delivers the most significant piece first. `order_sel`=0 delivers the least significant piece first.
- R5: Swap mode is a 2-bit code applied to the lanes of the word, where lane i is bits [9i+8:9i]. Output lane i takes input lane i XOR m. Code 00 means none (m=0). Code 01 reverses all four lanes (m=3). Code 10 exchanges the 18-bit halves (m=2). Code 11 exchanges the lanes within each half (m=1).
- R6: The swap code is sampled on the read that delivers the first piece of a long word. Changes to `swap_sel` on the later pieces of that word have no effect.
- R7: `size_sel` and `order_sel` are captured on one rising edge and become active on the next. A read on the capture edge still uses the old settings, and `mbox_sel` changes on the second edge.
- R8: Size code 11 raises `mbox_sel`. While it is active, reads do not pop the FIFO and do not change `dout`.
- R9: A read while `fifo_empty` is high is ignored. There is no pop, `dout` holds, and the piece position holds.
- R10: When the active bus size changes, the piece position restarts at the first piece.
- R11: After reset, `dout` is zero, `fifo_pop` and `mbox_sel` are low, and the active settings are long word with most-significant-first order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_data | input | 36 | Long word at the FIFO head |
| fifo_empty | input | 1 | FIFO holds no data |
| rd_en | input | 1 | Read request for this edge |
| size_sel | input | 2 | Bus size: 00 long, 01 word, 10 byte, 11 mailbox |
| order_sel | input | 1 | 1: most significant piece first |
| swap_sel | input | 2 | Byte-order swap mode |
| dout | output | 36 | Delivered piece, right-aligned |
| fifo_pop | output | 1 | One-cycle pop of the FIFO head |
| mbox_sel | output | 1 | Access is directed to the mailbox |

## Verification
A wrong piece counter shows at the ports right away. The `fifo_pop` pulse lands on the wrong read, and the lane on `dout` comes from the wrong position on the next accepted read. A wrong held swap code corrupts the second, third or fourth piece of a long word, and that is visible as soon as the piece is read. A fault in the size pipeline moves the `mbox_sel` edge, or the first read after a size change comes out at the wrong width, within two edges. The bench sweeps every size, order and swap combination. It changes `swap_sel` in the middle of a word, and it times the pipeline edge by edge.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_MBOX = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    SW_NONE = 2'b00,
    SW_BYTE = 2'b01,
    SW_HALF = 2'b10,
    SW_BOTH = 2'b11
  } swap_e;
endpackage

// File: rtl/bm_cfg_pipe.sv
module bm_cfg_pipe
  import bm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] size_in,
  input  logic       order_in,
  output size_e      size_act,
  output logic       order_act,
  output logic       size_chg
);
  size_e size_q1, size_q1_nxt, size_act_nxt;
  logic  order_q1, order_q1_nxt, order_act_nxt;

  always_comb begin
    size_q1_nxt   = size_e'(size_in);
    order_q1_nxt  = order_in;
    size_act_nxt  = size_q1;
    order_act_nxt = order_q1;
  end

  assign size_chg = (size_q1 != size_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q1   <= SZ_LONG;
      order_q1  <= 1'b1;
      size_act  <= SZ_LONG;
      order_act <= 1'b1;
    end else begin
      size_q1   <= size_q1_nxt;
      order_q1  <= order_q1_nxt;
      size_act  <= size_act_nxt;
      order_act <= order_act_nxt;
    end
  end
endmodule

// File: rtl/bm_swap.sv
module bm_swap
  import bm_pkg::*;
#(
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
)(
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        mode,
  output logic [DATA_W-1:0] dout
);
  logic [1:0] xm;

  always_comb begin
    case (swap_e'(mode))
      SW_BYTE: xm = 2'd3;
      SW_HALF: xm = 2'd2;
      SW_BOTH: xm = 2'd1;
      default: xm = 2'd0;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [1:0] src;
    assign src = 2'(i) ^ xm;
    assign dout[i*LANE_W +: LANE_W] = din[src*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/bm_slicer.sv
module bm_slicer
  import bm_pkg::*;
#(
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int HALF_W = 2 * LANE_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic [1:0]        swap_in,
  input  size_e             size_act,
  input  logic              order_act,
  input  logic              size_chg,
  output logic [DATA_W-1:0] dout,
  output logic              fifo_pop,
  output logic              mbox_sel
);
  logic [1:0]        cnt, cnt_nxt, last_idx, k;
  logic [1:0]        swap_hold, swap_hold_nxt, swap_eff;
  logic [DATA_W-1:0] swapped, piece, dout_nxt;
  logic              pop_nxt, rd_ok, is_last;

  assign mbox_sel = (size_act == SZ_MBOX);
  assign rd_ok    = rd_en && !fifo_empty && !mbox_sel;
  assign swap_eff = (cnt == 2'd0) ? swap_in : swap_hold;

  bm_swap #(.LANE_W(LANE_W)) swap_i (
    .din  (fifo_data),
    .mode (swap_eff),
    .dout (swapped)
  );

  always_comb begin
    case (size_act)
      SZ_WORD: last_idx = 2'd1;
      SZ_BYTE: last_idx = 2'd3;
      default: last_idx = 2'd0;
    endcase
    is_last = (cnt == last_idx);
    k       = order_act ? (last_idx - cnt) : cnt;
    piece   = '0;
    case (size_act)
      SZ_WORD: piece[HALF_W-1:0] = k[0] ? swapped[DATA_W-1:HALF_W] : swapped[HALF_W-1:0];
      SZ_BYTE: piece[LANE_W-1:0] = swapped[k*LANE_W +: LANE_W];
      default: piece = swapped;
    endcase
  end

  always_comb begin
    cnt_nxt       = cnt;
    swap_hold_nxt = swap_hold;
    dout_nxt      = dout;
    pop_nxt       = 1'b0;
    if (rd_ok) begin
      dout_nxt = piece;
      pop_nxt  = is_last;
      cnt_nxt  = is_last ? 2'd0 : cnt + 2'd1;
      if (cnt == 2'd0) swap_hold_nxt = swap_in;
    end
    if (size_chg) cnt_nxt = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= 2'd0;
      swap_hold <= 2'd0;
      dout      <= '0;
      fifo_pop  <= 1'b0;
    end else begin
      cnt       <= cnt_nxt;
      swap_hold <= swap_hold_nxt;
      dout      <= dout_nxt;
      fifo_pop  <= pop_nxt;
    end
  end

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fifo_empty) |=> (!fifo_pop && $stable(dout))); // R9
  AST_MBOX_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_sel && rd_en) |=> !fifo_pop); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_idx); // R3
  AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 2'd0 && $past(cnt) != 2'd0) |-> $stable(swap_hold)); // R6
  AST_POP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> $past(rd_en && !fifo_empty)); // R1
endmodule

// File: rtl/bm_rd_port.sv
module bm_rd_port
  import bm_pkg::*;
#(
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_empty,
  input  logic              rd_en,
  input  logic [1:0]        size_sel,
  input  logic              order_sel,
  input  logic [1:0]        swap_sel,
  output logic [DATA_W-1:0] dout,
  output logic              fifo_pop,
  output logic              mbox_sel
);
  size_e size_act;
  logic  order_act, size_chg;

  bm_cfg_pipe cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .size_in   (size_sel),
    .order_in  (order_sel),
    .size_act  (size_act),
    .order_act (order_act),
    .size_chg  (size_chg)
  );

  bm_slicer #(.LANE_W(LANE_W)) slicer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .swap_in    (swap_sel),
    .size_act   (size_act),
    .order_act  (order_act),
    .size_chg   (size_chg),
    .dout       (dout),
    .fifo_pop   (fifo_pop),
    .mbox_sel   (mbox_sel)
  );

  AST_MBOX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (size_sel != 2'b11) |=> ##1 (!mbox_sel || $past(size_sel) == 2'b11)); // R7
endmodule

// File: tb/bm_rd_port_tb.sv
module bm_rd_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] fifo_data = '0;
  logic        fifo_empty = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  size_sel = 2'b00;
  logic        order_sel = 1'b1;
  logic [1:0]  swap_sel = 2'b00;
  logic [35:0] dout;
  logic        fifo_pop, mbox_sel;
  int total = 0, bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  bm_rd_port dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .rd_en(rd_en), .size_sel(size_sel), .order_sel(order_sel), .swap_sel(swap_sel),
    .dout(dout), .fifo_pop(fifo_pop), .mbox_sel(mbox_sel)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] expect_piece(input logic [35:0] w, input int sz,
                                               input int ord, input int sw, input int p);
    int xm;
    logic [35:0] s;
    int k;
    xm = (sw == 1) ? 3 : (sw == 2) ? 2 : (sw == 3) ? 1 : 0;
    for (int i = 0; i < 4; i++) s[i*9 +: 9] = w[(i ^ xm)*9 +: 9];
    if (sz == 1) begin
      k = ord ? 1 - p : p;
      return {18'b0, s[k*18 +: 18]};
    end else if (sz == 2) begin
      k = ord ? 3 - p : p;
      return {27'b0, s[k*9 +: 9]};
    end
    return s;
  endfunction

  task automatic set_cfg(input int sz, input int ord);
    size_sel  = 2'(sz);
    order_sel = 1'(ord);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(input logic [35:0] w, input logic emp, input int sw);
    fifo_data  = w;
    fifo_empty = emp;
    swap_sel   = 2'(sw);
    rd_en      = 1'b1;
    @(negedge clk);
    rd_en      = 1'b0;
    fifo_empty = 1'b0;
  endtask

  initial begin
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [35:0] w;
    int np;
    repeat (2) @(negedge clk);
    chk("R11 dout", dout, 36'h0);
    chk("R11 pop", {35'b0, fifo_pop}, 36'h0);
    chk("R11 mbox", {35'b0, mbox_sel}, 36'h0);
    rst_n = 1'b1;
    @(negedge clk);
    w = 36'h1_2345_6789;
    do_read(w, 1'b0, 0);
    chk("R11 default long", dout, w);

    // Full sweep of size, order and swap (R1..R6)
    for (int sz = 0; sz < 3; sz++) begin
      for (int ord = 0; ord < 2; ord++) begin
        set_cfg(sz, ord);
        np = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int sw = 0; sw < 4; sw++) begin
          for (int n = 0; n < 2; n++) begin
            w = {4'(sw + n), 32'(32'h9E37_79B9 * (sz * 8 + ord * 4 + sw + n * 7 + 1))};
            for (int p = 0; p < np; p++) begin
              do_read(w, 1'b0, (p == 0) ? sw : (sw ^ (p + 1) % 4) ^ 1);
              chk(sz == 0 ? "R1/R5 data" : sz == 1 ? "R2/R4/R6 data" : "R3/R4/R6 data",
                  dout, expect_piece(w, sz, ord, sw, p));
              chk(sz == 0 ? "R1 pop" : sz == 1 ? "R2 pop" : "R3 pop",
                  {35'b0, fifo_pop}, {35'b0, p == np - 1});
            end
          end
        end
      end
    end

    // R9: empty read ignored in byte mode mid-word
    set_cfg(2, 1);
    w = 36'hA_BCDE_F012;
    do_read(w, 1'b0, 2);
    chk("R9 first piece", dout, expect_piece(w, 2, 1, 2, 0));
    do_read(36'h0, 1'b1, 0);
    chk("R9 empty dout holds", dout, expect_piece(w, 2, 1, 2, 0));
    chk("R9 empty no pop", {35'b0, fifo_pop}, 36'h0);
    for (int p = 1; p < 4; p++) begin
      do_read(w, 1'b0, 0);
      chk("R9 counter held", dout, expect_piece(w, 2, 1, 2, p));
    end
    chk("R9 pop after resume", {35'b0, fifo_pop}, 36'h1);

    // R8: mailbox select and latency (R7)
    size_sel = 2'b11;
    @(negedge clk);
    chk("R7 mbox after capture edge", {35'b0, mbox_sel}, 36'h0);
    @(negedge clk);
    chk("R7/R8 mbox after apply edge", {35'b0, mbox_sel}, 36'h1);
    w = dout;
    do_read(36'h5_5555_5555, 1'b0, 0);
    chk("R8 no pop", {35'b0, fifo_pop}, 36'h0);
    chk("R8 dout holds", dout, w);

    // R7/R10: read on capture edge uses old size; size change restarts counter
    set_cfg(2, 1);
    w = 36'h3_1415_9265;
    do_read(w, 1'b0, 0);
    chk("R3 byte piece0", dout, expect_piece(w, 2, 1, 0, 0));
    size_sel = 2'b00;
    do_read(w, 1'b0, 0);
    chk("R7 old size on capture edge", dout, expect_piece(w, 2, 1, 0, 1));
    chk("R7 no pop on capture edge", {35'b0, fifo_pop}, 36'h0);
    @(negedge clk);
    do_read(w, 1'b0, 1);
    chk("R10 long after change", dout, expect_piece(w, 0, 1, 1, 0));
    chk("R10 pop after change", {35'b0, fifo_pop}, 36'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule